// File: doc/BRIEF.md
# Negating-Operand Arithmetic Logic Unit

This block is a purely combinational integer ALU for a simple processor datapath. It takes two operands and a 3-bit control word and returns a result word, a zero flag and a signed overflow flag. The control word has two parts. The top bit inverts the second operand and feeds the adder a carry-in of one. The lower two bits choose what reaches the output: AND, OR, the adder output, or a set-on-less-than bit.

Because of this split, one adder serves addition, subtraction and signed comparison. The decode stage drives the control word. The zero flag is used for equality branches, where the two operands are subtracted and the flag is tested. The overflow flag reports when a signed add or subtract wraps. The set-on-less-than result stays correct even when the internal subtraction overflows.

Top module: `alu_negb`

## Requirements
- R1: Control 3'b000 drives the result with the bitwise AND of `op_a` and `op_b`.
- R2: Control 3'b001 drives the result with the bitwise OR of `op_a` and `op_b`.
- R3: Control 3'b010 drives the result with `op_a + op_b`, taken modulo 2^WIDTH.
- R4: Control 3'b110 drives the result with `op_a - op_b`, taken modulo 2^WIDTH.
- R5: Control 3'b111 drives the result with 1 when `op_a` is less than `op_b` as two's-complement signed numbers, and with 0 otherwise. All upper bits are zero. The answer is correct even where `op_a - op_b` overflows.
- R6: `zero` is 1 exactly when every bit of `result` is 0.
- R7: `ovf` is 1 only for controls 3'b010 and 3'b110, and only when the true signed sum or difference falls outside the signed range of WIDTH bits. For every other control it is 0.
- R8: The unused controls 3'b011, 3'b100 and 3'b101 drive a result of all zeros and `ovf` low, so `zero` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand; inverted when control bit 2 is set |
| ctl | input | 3 | Bit 2 negates the second operand; bits 1:0 select AND, OR, sum or less-than |
| result | output | WIDTH | Selected result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of an add or subtract |

## Verification
The block holds no state, so a wrong internal signal shows at the ports in the same evaluation as the input change that caused it. There is no delay and nothing to mask it. A carry-in or inversion error shows as a result off by one, or by the complement, under subtract. An error in the sign logic shows only near the signed range limits. For that reason the stimulus pairs the extreme values 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 0 with each control code. It then adds pseudo-random operands to cover ordinary values.

// File: rtl/alu_negb.sv
module alu_negb #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             negate;
  logic [1:0]       sel;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             sum_ovf;
  logic             less;
  logic             arith;

  assign negate = ctl[2];
  assign sel    = ctl[1:0];
  assign b_eff  = negate ? ~op_b : op_b;
  assign sum    = op_a + b_eff + {{MSB{1'b0}}, negate};

  assign sum_ovf = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
  assign less    = sum[MSB] ^ sum_ovf;
  assign arith   = (sel == 2'b10);

  always_comb begin
    result = '0;
    unique case (ctl)
      3'b000:  result = op_a & op_b;
      3'b001:  result = op_a | op_b;
      3'b010,
      3'b110:  result = sum;
      3'b111:  result = {{MSB{1'b0}}, less};
      default: result = '0;
    endcase
  end

  assign zero = ~|result;
  assign ovf  = arith && sum_ovf;
endmodule

module alu_negb_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       ctl,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf
);
  always_comb begin
    if (ctl == 3'b000) AST_AND_SUBSET: assert ((result & ~op_a) == '0 && (result & ~op_b) == '0); // R1
    if (ctl == 3'b001) AST_OR_COVERS: assert ((result & op_a) == op_a && (result & op_b) == op_b); // R2
    if (ctl == 3'b010) AST_ADD_UNDO: assert (result - op_b == op_a); // R3
    if (ctl == 3'b110) AST_SUB_UNDO: assert (result + op_b == op_a); // R4
    if (ctl == 3'b111) AST_SLT_ONE_BIT: assert (result[WIDTH-1:1] == '0); // R5
    AST_ZERO_FLAG: assert (zero == (result == '0)); // R6
    if (ctl != 3'b010 && ctl != 3'b110) AST_NO_OVERFLOW: assert (!ovf); // R7
    if (ctl == 3'b011 || ctl[2:1] == 2'b10) AST_UNUSED_CLEAR: assert (result == '0 && zero); // R8
  end
endmodule

bind alu_negb alu_negb_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu_negb_tb.sv
module alu_negb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         zf;
    logic         of;
    logic [2:0]   c;
    string        req;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2:0]   ctl = 3'b000;
  logic [W-1:0] result;
  logic zero, ovf;

  int compared = 0, mismatched = 0;
  bit done = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_negb #(.WIDTH(W)) dut_i (.op_a(op_a), .op_b(op_b), .ctl(ctl),
                               .result(result), .zero(zero), .ovf(ovf));

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] c);
    exp_t e;
    longint sa, sb_, wide;
    sa = longint'($signed(a));
    sb_ = longint'($signed(b));
    e.of = 1'b0;
    case (c)
      3'b000: e.res = a & b;
      3'b001: e.res = a | b;
      3'b010: begin
        e.res = a + b;
        wide = sa + sb_;
        e.of = (wide > 64'sh7FFF_FFFF) || (wide < -64'sh8000_0000);
      end
      3'b110: begin
        e.res = a - b;
        wide = sa - sb_;
        e.of = (wide > 64'sh7FFF_FFFF) || (wide < -64'sh8000_0000);
      end
      3'b111: e.res = (sa < sb_) ? 1 : 0;
      default: e.res = '0;
    endcase
    e.zf = (e.res == '0);
    e.c = c;
    e.req = req_of(c);
    @(posedge clk);
    op_a = a; op_b = b; ctl = c;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        compared += 3;
        if (result !== e.res) begin
          mismatched++;
          $display("FAIL %s result ctl=%b a=%h b=%h actual=%h expected=%h", e.req, e.c, op_a, op_b, result, e.res);
        end
        if (zero !== e.zf) begin
          mismatched++;
          $display("FAIL R6 zero ctl=%b actual=%b expected=%b", e.c, zero, e.zf);
        end
        if (ovf !== e.of) begin
          mismatched++;
          $display("FAIL R7 ovf ctl=%b a=%h b=%h actual=%b expected=%b", e.c, op_a, op_b, ovf, e.of);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  localparam logic [W-1:0] CORNER [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                          32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678};

  initial begin : stim
    logic [W-1:0] lfsr;
    lfsr = 32'hACE1_2468;
    repeat (3) @(posedge clk);
    // reset state: all-zero inputs give zero result, zero flag set (R6)
    @(negedge clk);
    compared++;
    if (result !== '0 || zero !== 1'b1 || ovf !== 1'b0) begin
      mismatched++;
      $display("FAIL R6 reset state actual=%h/%b/%b expected=0/1/0", result, zero, ovf);
    end
    rst = 0;
    // corners across every control code, including unused R8 codes
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          drive(CORNER[i], CORNER[j], 3'(c));
    // R5 signed compare where subtraction overflows
    drive(32'h8000_0000, 32'h0000_0001, 3'b111);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    // R4 equal operands give zero, flag set
    drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
    // R3 wraparound and R7 overflow
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    // pseudo-random operands
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      drive(a, b, 3'(n % 8));
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule